// File: doc/BRIEF.md
# Multi-Slot Serial Audio Frame Receiver

This block is the receiving end of a time-division-multiplexed audio link in which the block is clocked by the link's bit clock. Both the bit clock and the frame marker are supplied from outside. The block runs on the rising edge of that bit clock. It samples the frame marker and the serial data line on every edge. It finds the edge that opens a frame, counts bits into fixed 32-bit slots, and hands out one parallel word per slot. Each word comes with its slot number, a strobe and a marker for slot 0.

Six framing conventions can be chosen at run time through `i_fmt`. They differ in three ways: the polarity of the frame-opening edge, whether the first data bit trails that edge by one bit, and whether the audio sample sits at the head or the tail of the slot. Codes 6 and 7 are decoded like code 1. The frame size is also picked at run time, from 4, 8, 12 or 16 slots. An optional mode hands each slot out as two 16-bit halves, for a slot that carries two narrow channels.

The receiver flags malformed frames. A frame-opening edge that arrives too early is flagged. So is an expected edge that never comes. The receiver then realigns on the next frame-opening edge.

Top module: `tdm_slave_rx`

## Requirements
- R1: The frame-opening edge is a falling edge of `i_fsync` for `i_fmt` codes 0 and 5, and a rising edge for codes 1, 2, 3 and 4. An edge of the other polarity does not open a frame.
- R2: For codes 0, 3 and 5, the first data bit of a frame is sampled on the rising edge that follows the one on which the opening edge is seen. For codes 1, 2 and 4, it is sampled on the same rising edge that sees the opening edge.
- R3: Slots are 32 bits long and arrive MSB first. `i_frame_sel` values 0, 1, 2 and 3 select 4, 8, 12 and 16 slots per frame (128, 256, 384 and 512 bits). Slot words are delivered in increasing slot order.
- R4: With `i_split` low, `o_sample` carries a 24-bit sample. For code 2 it is the last 24 bits of the slot. For every other code it is the first 24 bits of the slot. `o_half_hi` and `o_half_lo` are zero.
- R5: With `i_split` high, `o_half_hi` carries the first 16 bits of the slot, `o_half_lo` carries the last 16 bits, and `o_sample` is zero.
- R6: `o_valid` pulses for one cycle, on the cycle after the rising edge that samples the last bit of a slot. `o_slot` then carries that slot's index, and `o_first` is high exactly when the index is 0.
- R7: After reset all outputs are zero. No word is delivered until the first frame-opening edge has been seen.
- R8: If a frame-opening edge arrives before the current frame has received all of its bits, `o_sync_err` pulses for one cycle. That edge is then taken as the start of a new frame, and the partial slot is dropped.
- R9: If a frame ends without its expected opening edge, `o_sync_err` pulses for one cycle. The frame's last slot is still delivered. No further words are delivered until the next frame-opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_fsync | input | 1 | Frame marker from the transmitting side |
| i_sdata | input | 1 | Serial data line |
| i_fmt | input | 3 | Framing convention code (0 to 5) |
| i_frame_sel | input | 2 | Frame size: (value+1)*4 slots |
| i_split | input | 1 | Deliver each slot as two 16-bit halves |
| o_valid | output | 1 | One-cycle strobe for a delivered slot word |
| o_slot | output | 4 | Index of the delivered slot |
| o_first | output | 1 | High with the word of slot 0 |
| o_sample | output | 24 | Justified sample when not split |
| o_half_hi | output | 16 | First half of the slot when split |
| o_half_lo | output | 16 | Second half of the slot when split |
| o_sync_err | output | 1 | One-cycle pulse on a malformed frame |

## Verification
Each of the six conventions is driven through two back-to-back frames, using its own marker waveform (half-frame level or single-bit pulse) and its own frame size. Every slot carries a distinct word, so a wrong edge polarity, a lost or extra one-bit lag, or the wrong justification shows up as shifted or misaligned data. Two split-mode runs, one lagging and one not, check that the halves come from the right end of the slot. Directed cases cover four situations: a marker that never moves, a frame cut short by an early pulse, with and without lag, and a frame whose closing edge never comes. These show whether realignment and the error pulse land on the right frame.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  timeunit 1ns; timeprecision 1ps;

  // framing properties that the receive path actually depends on
  typedef struct packed {
    logic fall_start;   // frame opens on a falling marker edge
    logic one_bit_lag;  // data trails the marker edge by one bit
    logic tail_align;   // sample sits at the end of the slot
  } fmt_cfg_t;

  typedef enum logic {ST_HUNT, ST_RUN} rx_state_e;

  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
    fmt_cfg_t c;
    c = '0;
    case (code)
      3'd0, 3'd5: begin c.fall_start = 1'b1; c.one_bit_lag = 1'b1; end
      3'd2:       c.tail_align  = 1'b1;
      3'd3:       c.one_bit_lag = 1'b1;
      default:    c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tdmrx_edge.sv
module tdmrx_edge (
  input  logic clk,
  input  logic rst,
  input  logic fsync,
  input  logic fall_start,
  output logic start
);
  timeunit 1ns; timeprecision 1ps;

  logic prev_q, primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= fsync;
      primed_q <= 1'b1;
    end
  end

  assign start = primed_q && (fall_start ? (prev_q && !fsync) : (!prev_q && fsync));

  // two same-polarity edges cannot sit on adjacent samples (R1)
  p_edge_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> !(start && $stable(fall_start)));
endmodule

// File: rtl/tdmrx_frame_ctr.sv
module tdmrx_frame_ctr #(
  parameter int SLOT_W    = 32,
  parameter int MAX_SLOTS = 16,
  localparam int BW    = $clog2(SLOT_W),
  localparam int SW    = $clog2(MAX_SLOTS + 1),
  localparam int IDX_W = $clog2(MAX_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             lag,
  input  logic [SW-1:0]    n_slots,
  output logic             emit,
  output logic [IDX_W-1:0] slot_idx,
  output logic             err
);
  timeunit 1ns; timeprecision 1ps;
  import tdmrx_pkg::*;

  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_W - 1);

  rx_state_e     st_q, st_d;
  logic [BW-1:0] b_q, b_d;
  logic [SW-1:0] s_q, s_d;
  logic          at_last, past_end, expect_edge;

  assign at_last     = (s_q == n_slots - 1'b1) && (b_q == LAST_BIT);
  assign past_end    = (s_q >= n_slots);
  assign expect_edge = lag ? at_last : past_end;
  assign slot_idx    = s_q[IDX_W-1:0];

  always_comb begin
    st_d = st_q;
    b_d  = b_q;
    s_d  = s_q;
    emit = 1'b0;
    err  = 1'b0;
    if (start) begin
      st_d = ST_RUN;
      s_d  = '0;
      // lagging data: this edge also carries the last bit of the old frame
      b_d  = lag ? '0 : BW'(1);
      if (st_q == ST_RUN) begin
        if (!expect_edge) err = 1'b1;
        else if (lag)     emit = 1'b1;
      end
    end else if (st_q == ST_RUN) begin
      if (past_end) begin
        err  = 1'b1;
        st_d = ST_HUNT;
      end else if (b_q == LAST_BIT) begin
        emit = 1'b1;
        b_d  = '0;
        s_d  = s_q + 1'b1;
        if (lag && at_last) begin
          err  = 1'b1;
          st_d = ST_HUNT;
        end
      end else begin
        b_d = b_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_HUNT;
      b_q  <= '0;
      s_q  <= '0;
    end else begin
      st_q <= st_d;
      b_q  <= b_d;
      s_q  <= s_d;
    end
  end

  // lock is only ever gained from a frame-opening edge (R7)
  p_lock_from_edge_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_RUN) |-> $past(start));
  // while running the slot counter never passes the frame end (R3)
  p_slot_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (s_q <= n_slots));
  // an error is followed by at least one clean cycle (R8)
  p_err_isolated_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // a missing edge leaves the counter unlocked (R9)
  p_unlock_on_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> (st_q == ST_HUNT));
endmodule

// File: rtl/tdmrx_word_out.sv
module tdmrx_word_out #(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int IDX_W    = 4,
  localparam int HALF_W  = SLOT_W / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdata,
  input  logic                emit,
  input  logic [IDX_W-1:0]    slot_idx,
  input  logic                err,
  input  logic                tail_align,
  input  logic                split,
  output logic                valid_q,
  output logic [IDX_W-1:0]    slot_q,
  output logic                first_q,
  output logic [SAMPLE_W-1:0] sample_q,
  output logic [HALF_W-1:0]   hi_q,
  output logic [HALF_W-1:0]   lo_q,
  output logic                err_q
);
  timeunit 1ns; timeprecision 1ps;

  logic [SLOT_W-2:0]   sh_q;
  logic [SLOT_W-1:0]   word;
  logic [SAMPLE_W-1:0] pick;

  // free-running: at a slot's last bit the newest SLOT_W bits are the slot
  assign word = {sh_q, sdata};
  assign pick = tail_align ? word[SAMPLE_W-1:0] : word[SLOT_W-1 -: SAMPLE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      valid_q  <= 1'b0;
      slot_q   <= '0;
      first_q  <= 1'b0;
      sample_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      sh_q    <= word[SLOT_W-2:0];
      valid_q <= emit;
      err_q   <= err;
      if (emit) begin
        slot_q   <= slot_idx;
        first_q  <= (slot_idx == '0);
        sample_q <= split ? '0 : pick;
        hi_q     <= split ? word[SLOT_W-1:HALF_W] : '0;
        lo_q     <= split ? word[HALF_W-1:0] : '0;
      end
    end
  end

  // strobes are single cycles, never back to back (R6)
  p_valid_gap_r6: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // sample and halves are never both populated (R5)
  p_split_excl_r5: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((sample_q == '0) || ((hi_q == '0) && (lo_q == '0))));
endmodule

// File: rtl/tdm_slave_rx.sv
module tdm_slave_rx #(
  parameter int SLOT_W     = 32,
  parameter int SAMPLE_W   = 24,
  parameter int SLOTS_STEP = 4,
  parameter int SEL_W      = 2,
  localparam int MAX_SLOTS = SLOTS_STEP * (1 << SEL_W),
  localparam int SW        = $clog2(MAX_SLOTS + 1),
  localparam int IDX_W     = $clog2(MAX_SLOTS),
  localparam int HALF_W    = SLOT_W / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                i_fsync,
  input  logic                i_sdata,
  input  logic [2:0]          i_fmt,
  input  logic [SEL_W-1:0]    i_frame_sel,
  input  logic                i_split,
  output logic                o_valid,
  output logic [IDX_W-1:0]    o_slot,
  output logic                o_first,
  output logic [SAMPLE_W-1:0] o_sample,
  output logic [HALF_W-1:0]   o_half_hi,
  output logic [HALF_W-1:0]   o_half_lo,
  output logic                o_sync_err
);
  timeunit 1ns; timeprecision 1ps;
  import tdmrx_pkg::*;

  fmt_cfg_t         cfg;
  logic [SW-1:0]    n_slots;
  logic             start, emit, err;
  logic [IDX_W-1:0] slot_idx;

  assign cfg     = decode_fmt(i_fmt);
  assign n_slots = SW'((int'(i_frame_sel) + 1) * SLOTS_STEP);

  tdmrx_edge u_edge (
    .clk(clk), .rst(rst), .fsync(i_fsync),
    .fall_start(cfg.fall_start), .start(start)
  );

  tdmrx_frame_ctr #(.SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS)) u_ctr (
    .clk(clk), .rst(rst), .start(start), .lag(cfg.one_bit_lag),
    .n_slots(n_slots), .emit(emit), .slot_idx(slot_idx), .err(err)
  );

  tdmrx_word_out #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .sdata(i_sdata), .emit(emit), .slot_idx(slot_idx),
    .err(err), .tail_align(cfg.tail_align), .split(i_split),
    .valid_q(o_valid), .slot_q(o_slot), .first_q(o_first), .sample_q(o_sample),
    .hi_q(o_half_hi), .lo_q(o_half_lo), .err_q(o_sync_err)
  );

  // slot-0 marker agrees with the delivered index (R6)
  p_first_is_slot0_r6: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_first) |-> (o_slot == '0));
  // delivered slot indices stay inside the selected frame (R3)
  p_slot_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    (o_valid && $stable(i_frame_sel)) |-> (IDX_W'(o_slot) < n_slots));
endmodule

// File: tb/test_tdm_slave_rx.sv
module test_tdm_slave_rx;
  timeunit 1ns; timeprecision 1ps;

  localparam int SLOT_W = 32;

  logic        clk = 1'b0, rst = 1'b1, fsync = 1'b0, sdata = 1'b0, split = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  fsel = 2'd0;
  logic        o_valid, o_first, o_sync_err;
  logic [3:0]  o_slot;
  logic [23:0] o_sample;
  logic [15:0] o_half_hi, o_half_lo;

  int total = 0, bad = 0;
  int n_valid = 0, n_err = 0, prev_slot = 0;
  logic [31:0] mon_seed = 32'h0;

  always #2 clk = ~clk;

  tdm_slave_rx i_tdm_slave_rx (
    .clk(clk), .rst(rst), .i_fsync(fsync), .i_sdata(sdata), .i_fmt(fmt),
    .i_frame_sel(fsel), .i_split(split), .o_valid(o_valid), .o_slot(o_slot),
    .o_first(o_first), .o_sample(o_sample), .o_half_hi(o_half_hi),
    .o_half_lo(o_half_lo), .o_sync_err(o_sync_err)
  );

  function automatic logic [31:0] pat(input logic [31:0] seed, input int slot);
    return (seed ^ {8'(slot), 24'h0}) + 32'(slot) * 32'h0135_79BD;
  endfunction

  function automatic logic lvl(input logic [2:0] f, input int rel, input int fl);
    case (f)
      3'd0, 3'd5: return (rel < fl / 2) ? 1'b0 : 1'b1;
      3'd3, 3'd4: return (rel == 0);
      default:    return (rel < fl / 2);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor: every delivered word is checked against the requirements
  always @(negedge clk) begin
    if (!rst) begin
      if (o_sync_err) n_err++;
      if (o_valid) begin : mon
        logic [31:0] w;
        logic [23:0] es;
        int ns;
        ns = (int'(fsel) + 1) * 4;
        w  = pat(mon_seed, int'(o_slot));
        chk((int'(o_slot) < ns) && (o_slot == 0 || int'(o_slot) == prev_slot + 1)
            && (o_first == (o_slot == 0)), "R6 slot index/first",
            {27'd0, o_first, o_slot}, 32'(prev_slot + 1));
        if (split) begin
          chk(o_half_hi == w[31:16] && o_half_lo == w[15:0] && o_sample == 0,
              "R5 split halves", {o_half_hi, o_half_lo}, w);
        end else begin
          es = (fmt == 3'd2) ? w[23:0] : w[31:8];
          chk(o_sample == es && o_half_hi == 0 && o_half_lo == 0,
              "R3 R4 justified sample", {8'd0, o_sample}, {8'd0, es});
        end
        prev_slot = int'(o_slot);
        n_valid++;
      end
    end
  end

  task automatic start_run(input logic [2:0] f, input logic [1:0] s, input bit sp, input logic [31:0] seed);
    @(negedge clk);
    rst = 1'b1;
    fmt = f; fsel = s; split = sp; mon_seed = seed;
    fsync = lvl(f, (int'(s) + 1) * 128 - 1, (int'(s) + 1) * 128);
    sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 n_valid = 0; n_err = 0; prev_slot = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frames(input int nframes, input int first_len, input bit close, input int idle);
    int fl;
    bit d;
    logic u, uprev;
    logic [31:0] w;
    fl = (int'(fsel) + 1) * 4 * SLOT_W;
    d = (fmt == 3'd0) || (fmt == 3'd3) || (fmt == 3'd5);
    uprev = 1'b0;
    for (int k = 0; k < nframes; k++) begin
      for (int rel = 0; rel < ((k == 0) ? first_len : fl); rel++) begin
        w = pat(mon_seed, rel / SLOT_W);
        u = w[SLOT_W - 1 - (rel % SLOT_W)];
        @(negedge clk);
        fsync = lvl(fmt, rel, fl);
        sdata = d ? uprev : u;
        uprev = u;
      end
    end
    @(negedge clk);
    fsync = close ? lvl(fmt, 0, fl) : lvl(fmt, fl - 1, fl);
    sdata = d ? uprev : 1'b0;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      sdata = i[0];
    end
  endtask

  task automatic expect_counts(input int ev, input int ee, input string tag);
    repeat (2) @(negedge clk);
    #1;
    chk(n_valid == ev, {tag, " word count"}, 32'(n_valid), 32'(ev));
    chk(n_err == ee, {tag, " error count"}, 32'(n_err), 32'(ee));
  endtask

  // fmt[37:35] frame_sel[34:33] split[32] seed[31:0]
  localparam logic [37:0] VEC [8] = '{
    {3'd0, 2'd1, 1'b0, 32'h1234_5678},
    {3'd1, 2'd0, 1'b0, 32'h9ABC_DEF1},
    {3'd2, 2'd1, 1'b0, 32'h0F0F_33CC},
    {3'd3, 2'd2, 1'b0, 32'h8000_0001},
    {3'd4, 2'd3, 1'b0, 32'h5A5A_A5A5},
    {3'd5, 2'd0, 1'b0, 32'hDEAD_BEEF},
    {3'd1, 2'd1, 1'b1, 32'h1357_9BDF},
    {3'd0, 2'd0, 1'b1, 32'h2468_ACE0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    chk(o_valid == 0 && o_sync_err == 0 && o_first == 0 && o_slot == 0,
        "R7 reset flags", {28'd0, o_valid, o_sync_err, o_first, 1'b0}, 32'd0);
    chk(o_sample == 0 && o_half_hi == 0 && o_half_lo == 0, "R7 reset data",
        {8'd0, o_sample}, 32'd0);

    // R1 R2 R3 R4 R5: every convention, two frames each
    for (int i = 0; i < 8; i++) begin
      int fl;
      fl = (int'(VEC[i][34:33]) + 1) * 4 * SLOT_W;
      start_run(VEC[i][37:35], VEC[i][34:33], VEC[i][32], VEC[i][31:0]);
      run_frames(2, fl, 1'b1, 3);
      expect_counts(2 * fl / SLOT_W, 0, "R1 R2 R3 frame lock");
    end

    // R7: marker never moves, data toggles -> nothing delivered
    start_run(3'd1, 2'd0, 1'b0, 32'h1111_2222);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      sdata = i[1];
    end
    expect_counts(0, 0, "R7 no edge");

    // R8: early pulse, without and with one-bit lag
    start_run(3'd4, 2'd0, 1'b0, 32'h3C3C_5A5A);
    run_frames(2, 40, 1'b1, 3);
    expect_counts(5, 1, "R8 early edge no lag");
    start_run(3'd3, 2'd0, 1'b0, 32'h7777_0123);
    run_frames(2, 40, 1'b1, 3);
    expect_counts(5, 1, "R8 early edge lag");

    // R9: closing edge never arrives
    start_run(3'd1, 2'd0, 1'b0, 32'hCAFE_0001);
    run_frames(1, 128, 1'b0, 80);
    expect_counts(4, 1, "R9 missing edge no lag");
    start_run(3'd0, 2'd1, 1'b0, 32'hBEEF_0002);
    run_frames(1, 256, 1'b0, 80);
    expect_counts(8, 1, "R9 missing edge lag");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule